// File: doc/BRIEF.md
# Handshaked Serial Byte Transfer Engine

This block is the host side of a byte link to a power-management microcontroller. A local requester gives it a direction and, for a send, a byte. The engine sets the mode of its 8-bit shift register. Bits move through that register on edges of a shift clock driven by the far side. The engine then runs a four-phase exchange on two active-low lines: a request output and an acknowledge input. When the exchange closes, it returns a done pulse and the byte it captured.

The length of a byte transfer is not set by counting shift clocks. The transfer is complete when the far side pulls acknowledge low after the engine lowers request, and then lets acknowledge rise again after request is released. The acknowledge input and the serial inputs pass through a two-flop synchronizer. A timeout limit applies to every wait for acknowledge. When the limit expires, the transfer is abandoned and completes with an error flag.

Top module: `hs_byte_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `hs_req_n` is 1, `done` and `done_err` are 0, `mode` is 3'b000 and `sh_dout` is 0.
- R2: A request is taken only when `req_ready` is 1. `req_valid` asserted while a transfer is running has no effect: no further done pulse appears, and the byte in flight is not changed.
- R3: For a send (`req_send`=1), `mode` becomes 3'b111 (bit 2 = shift out, bits 1:0 = 2'b11 external clock). The byte is presented on `sh_dout` MSB first, and advances one bit per rising edge of `sh_clk`.
- R4: For a receive (`req_send`=0), `mode` becomes 3'b011 and the register is cleared. `sh_din` is shifted in at the LSB on each rising edge of `sh_clk`, so the first bit received ends up as the MSB of `done_data`.
- R5: `hs_req_n` goes low in the cycle after a request is accepted. It is driven high again only after a low acknowledge has been seen. Completion follows only after acknowledge is seen high again.
- R6: Each accepted request produces exactly one `done` pulse of one cycle. On that pulse, `hs_req_n` and `req_ready` are 1. `done_err` is 0 when the exchange completes normally.
- R7: If acknowledge does not change within `tmo_limit` cycles of a wait starting, the engine releases `hs_req_n`, pulses `done` with `done_err`=1 and returns to idle. This happens at the `tmo_limit`-th clock edge after entering the wait.
- R8: `hs_ack_n` passes through two synchronizer flops. `hs_req_n` rises at the third clock edge after `hs_ack_n` falls. `done` is asserted at the third clock edge after `hs_ack_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request strobe |
| req_send | input | 1 | 1 = send byte, 0 = receive byte |
| req_data | input | 8 | Byte to send |
| tmo_limit | input | 16 | Cycles allowed per acknowledge wait |
| req_ready | output | 1 | Engine idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a timeout abort |
| done_data | output | 8 | Shift register contents at completion |
| mode | output | 3 | Shift mode field: {shift out, external clock[1:0]} |
| hs_req_n | output | 1 | Active-low transfer request |
| hs_ack_n | input | 1 | Active-low transfer acknowledge |
| sh_clk | input | 1 | Shift clock from the far side |
| sh_din | input | 1 | Serial data in |
| sh_dout | output | 1 | Serial data out (register MSB) |

## Verification
Each result has a fixed number of clock edges after its stimulus:
- `hs_req_n` falls at the accept edge.
- `hs_req_n` rises at the third edge after acknowledge falls.
- `done` is asserted at the third edge after acknowledge rises.
- A timeout abort lands on exactly the `tmo_limit`-th edge after the wait begins.

The bench changes inputs on falling edges and counts rising edges from there. It samples at the falling edge just before the due edge to confirm that nothing has changed early, then samples at the falling edge after the due edge to confirm the change. Checks on serial data read the bits the responder captured, and `done_data`, only after the done pulse.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACK_LO = 2'd1,
    ST_ACK_HI = 2'd2
  } hsb_state_e;

  // mode field: bit 2 = shift out, bits 1:0 = external clock select
  localparam logic [2:0] MODE_OFF = 3'b000;
  localparam logic [2:0] MODE_TX  = 3'b111;
  localparam logic [2:0] MODE_RX  = 3'b011;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsb_shifter.sv
module hsb_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          en,
  input  logic          dir_out,
  input  logic          sclk_s,
  input  logic          sdin_s,
  output logic          sdout,
  output logic [DW-1:0] value
);
  logic [DW-1:0] sr;
  logic          sclk_q;
  logic          rise;

  assign rise = sclk_s & ~sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      if (load) begin
        sr <= load_val;
      end else if (en && rise) begin
        sr <= {sr[DW-2:0], (dir_out ? 1'b0 : sdin_s)};
      end
    end
  end

  assign sdout = sr[DW-1];
  assign value = sr;
endmodule

// File: rtl/hsb_timer.sv
module hsb_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;
  logic [CW:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign expired  = run && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run && !expired) begin
      cnt <= next_cnt[CW-1:0];
    end
  end
endmodule

// File: rtl/hs_byte_engine.sv
module hs_byte_engine
  import hsb_pkg::*;
#(
  parameter int DW = 8,
  parameter int TMO_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_send,
  input  logic [DW-1:0]    req_data,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             req_ready,
  output logic             done,
  output logic             done_err,
  output logic [DW-1:0]    done_data,
  output logic [2:0]       mode,
  output logic             hs_req_n,
  input  logic             hs_ack_n,
  input  logic             sh_clk,
  input  logic             sh_din,
  output logic             sh_dout
);
  hsb_state_e    st;
  logic          ack_s;
  logic [1:0]    ser_s;
  logic [DW-1:0] sr_val;
  logic          accept;
  logic          tmo_clear;
  logic          tmo_run;
  logic          tmo_exp;
  logic          ready_q, done_q, err_q, req_n_q;
  logic [DW-1:0] data_q;
  logic [2:0]    mode_q;

  hsb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst(rst), .d(hs_ack_n), .q(ack_s)
  );

  hsb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_ser_sync (
    .clk(clk), .rst(rst), .d({sh_clk, sh_din}), .q(ser_s)
  );

  assign accept = (st == ST_IDLE) && req_valid;

  hsb_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst),
    .load(accept),
    .load_val(req_send ? req_data : '0),
    .en(st == ST_ACK_LO),
    .dir_out(mode_q[2]),
    .sclk_s(ser_s[1]),
    .sdin_s(ser_s[0]),
    .sdout(sh_dout),
    .value(sr_val)
  );

  assign tmo_clear = accept || ((st == ST_ACK_LO) && !ack_s);
  assign tmo_run   = ((st == ST_ACK_LO) && ack_s) || ((st == ST_ACK_HI) && !ack_s);

  hsb_timer #(.CW(TMO_W)) u_tmo (
    .clk(clk), .rst(rst), .clear(tmo_clear), .run(tmo_run),
    .limit(tmo_limit), .expired(tmo_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ready_q <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      req_n_q <= 1'b1;
      data_q  <= '0;
      mode_q  <= MODE_OFF;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            st      <= ST_ACK_LO;
            ready_q <= 1'b0;
            req_n_q <= 1'b0;
            mode_q  <= req_send ? MODE_TX : MODE_RX;
          end
        end
        ST_ACK_LO: begin
          if (!ack_s) begin
            req_n_q <= 1'b1;
            st      <= ST_ACK_HI;
          end else if (tmo_exp) begin
            req_n_q <= 1'b1;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            ready_q <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        ST_ACK_HI: begin
          if (ack_s) begin
            done_q  <= 1'b1;
            data_q  <= sr_val;
            ready_q <= 1'b1;
            st      <= ST_IDLE;
          end else if (tmo_exp) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            ready_q <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = ready_q;
  assign done      = done_q;
  assign done_err  = err_q;
  assign done_data = data_q;
  assign mode      = mode_q;
  assign hs_req_n  = req_n_q;
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       done_err,
  input logic [2:0] mode,
  input logic       hs_req_n,
  input logic       hs_ack_n
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !hs_req_n)); // R2

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> hs_req_n); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> (hs_req_n && req_ready)); // R6

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    done_err |-> done); // R7

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(mode)); // R3

  AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_req_n) && !done_err) |-> !$past(hs_ack_n, 3)); // R8
endmodule

bind hs_byte_engine hsb_checker u_hsb_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .done_err(done_err), .mode(mode),
  .hs_req_n(hs_req_n), .hs_ack_n(hs_ack_n)
);

// File: tb/hs_byte_engine_tb_top.sv
`timescale 1ns/1ps
module hs_byte_engine_tb_top;
  localparam int DW = 8;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_send = 1'b0;
  logic [DW-1:0] req_data = '0;
  logic [15:0] tmo_limit = 16'd1000;
  logic req_ready, done, done_err, hs_req_n, sh_dout;
  logic [DW-1:0] done_data;
  logic [2:0] mode;
  logic hs_ack_n = 1'b1, sh_clk = 1'b0, sh_din = 1'b0;

  int checks = 0, errors = 0, done_cnt = 0;
  int resp_mode = 0;            // 0 = automatic responder, 1 = manual
  logic [DW-1:0] resp_byte = '0;
  logic [DW-1:0] cap = '0;

  always #2 clk = ~clk;          // 250 MHz

  hs_byte_engine dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_send(req_send),
    .req_data(req_data), .tmo_limit(tmo_limit), .req_ready(req_ready),
    .done(done), .done_err(done_err), .done_data(done_data), .mode(mode),
    .hs_req_n(hs_req_n), .hs_ack_n(hs_ack_n), .sh_clk(sh_clk),
    .sh_din(sh_din), .sh_dout(sh_dout)
  );

  always @(negedge clk) if (done) done_cnt++;

  // vector: {send, tx byte, byte returned by far side}
  localparam logic [16:0] VECS [NV] = '{
    {1'b1, 8'hA5, 8'h00}, {1'b0, 8'h00, 8'h3C}, {1'b1, 8'h01, 8'h00},
    {1'b0, 8'h00, 8'h80}, {1'b1, 8'hFF, 8'h00}, {1'b0, 8'h00, 8'h5B}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic snd, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_send = snd; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  // far-side responder
  initial begin
    forever begin
      @(negedge clk);
      if (resp_mode == 0 && hs_req_n == 1'b0) begin
        for (int i = DW-1; i >= 0; i--) begin
          if (mode[2]) cap[i] = sh_dout; else sh_din = resp_byte[i];
          repeat (4) @(negedge clk);
          sh_clk = 1'b1;
          repeat (4) @(negedge clk);
          sh_clk = 1'b0;
        end
        hs_ack_n = 1'b0;
        while (hs_req_n == 1'b0) @(negedge clk);
        repeat (2) @(negedge clk);
        hs_ack_n = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(hs_req_n == 1'b1, "R1 hs_req_n", hs_req_n, 1);
    chk(done == 1'b0 && done_err == 1'b0, "R1 done", done, 0);
    chk(mode == 3'b000, "R1 mode", mode, 0);
    chk(sh_dout == 1'b0, "R1 sh_dout", sh_dout, 0);

    // table walk: R3 send, R4 receive, R6 completion
    for (int v = 0; v < NV; v++) begin
      logic snd;
      logic [DW-1:0] tx, rx;
      {snd, tx, rx} = VECS[v];
      resp_byte = rx;
      base = done_cnt;
      issue(snd, tx);
      if (snd) chk(mode == 3'b111, "R3 mode", mode, 7);
      else     chk(mode == 3'b011, "R4 mode", mode, 3);
      chk(hs_req_n == 1'b0, "R5 request low after accept", hs_req_n, 0);
      wait_done(seen);
      chk(seen && !done_err, "R6 done without error", done_err, 0);
      if (snd) chk(cap == tx, "R3 bits shifted out", cap, tx);
      else     chk(done_data == rx, "R4 bits shifted in", done_data, rx);
      @(negedge clk);
      chk(done == 1'b0, "R6 one-cycle done", done, 0);
      chk(done_cnt == base + 1, "R6 done count", done_cnt - base, 1);
    end

    // R2: request while busy is ignored
    base = done_cnt;
    issue(1'b1, 8'hC3);
    for (int i = 0; i < 10; i++) begin
      req_valid = 1'b1; req_send = 1'b1; req_data = 8'h3C;
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_done(seen);
    chk(cap == 8'hC3, "R2 byte in flight unchanged", cap, 8'hC3);
    repeat (50) @(negedge clk);
    chk(done_cnt == base + 1, "R2 busy request ignored", done_cnt - base, 1);
    chk(hs_req_n == 1'b1 && req_ready == 1'b1, "R2 stays idle", hs_req_n, 1);

    // R5/R8: exact handshake latency, manual far side
    resp_mode = 1;
    issue(1'b1, 8'h5A);
    chk(hs_req_n == 1'b0, "R5 request low", hs_req_n, 0);
    hs_ack_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(hs_req_n == 1'b0, "R8 request held before sync", hs_req_n, 0);
    @(negedge clk);
    chk(hs_req_n == 1'b1, "R8 request released at third edge", hs_req_n, 1);
    chk(done == 1'b0, "R5 no done before ack high", done, 0);
    hs_ack_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R8 done not early", done, 0);
    @(negedge clk);
    chk(done == 1'b1 && done_err == 1'b0, "R8 done at third edge", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R6 single pulse", done, 0);

    // R7: timeout abort with silent far side
    tmo_limit = 16'd20;
    issue(1'b0, 8'h00);
    repeat (19) @(negedge clk);
    chk(done == 1'b0, "R7 no abort before limit", done, 0);
    @(negedge clk);
    chk(done == 1'b1 && done_err == 1'b1, "R7 abort with error", {done, done_err}, 3);
    chk(hs_req_n == 1'b1 && req_ready == 1'b1, "R7 released and idle", {hs_req_n, req_ready}, 3);

    // recovery after abort
    resp_mode = 0;
    tmo_limit = 16'd1000;
    resp_byte = 8'h96;
    issue(1'b0, 8'h00);
    wait_done(seen);
    chk(seen && !done_err && done_data == 8'h96, "R4 receive after abort", done_data, 8'h96);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule